// File: doc/BRIEF.md
# Nonvolatile Store/Recall Arbitration Controller

This controller decides when an SRAM array and its nonvolatile shadow exchange data. A store copies the array into the shadow. A recall first clears the array and then loads it back from the shadow. Four sources can ask for a transfer:

- a software store request,
- a software recall request,
- an external device pulling a shared active-low handshake line,
- a rising power-fail indication from a supply comparator.

While a transfer runs, the controller blocks host access to the array. Throughout every store it pulls the handshake line low as a busy signal.

A dirty flag records whether any host write has been accepted since the last completed transfer. Stores requested by the handshake line or by power-fail are dropped when the flag is clear. Software stores ignore the flag.

A request from the handshake line or from power-fail does not start the store at once. It first opens a delay window. Reads continue during the window, and a write already in progress may finish. New writes are held off from the moment the line is seen low until it is seen high again. A request that arrives while the other kind of transfer is running waits in a queue and is served when that transfer ends. All durations are parameters counted in clock cycles.

Top module: `nvsr_ctrl`

## Requirements
- R1: The dirty flag is set by a host write that was accepted (`host_wr` high while `wr_inhibit` low). It is cleared when a store or a recall completes. Writes rejected by `wr_inhibit` leave it unchanged.
- R2: A store requested by the handshake line or by power-fail is discarded, with no transfer, when the dirty flag is clear at the moment the request is considered.
- R3: A software store always runs, whatever the dirty flag. With no host access under way, `xfer_store` rises one cycle after the request pulse and stays high for STORE_CYC cycles.
- R4: The handshake line is read through a SYNC_STAGES-flop synchroniser, and a high-to-low transition of the line is the request. With the flag set, a delay window of DELAY_CYC cycles follows. The store then begins SYNC_STAGES+1+DELAY_CYC cycles after the line falls. Host reads during the window do not move the store.
- R5: `wr_inhibit` is high during any transfer and during the delay window. It is also high while the synchronised line is low, except for a write that was already accepted in the previous cycle: that write stays allowed until `host_wr` drops. The inhibit lifts SYNC_STAGES cycles after the line returns high.
- R6: `hs_pull_en` (1 = pull the line low) is high during every cycle of every store, whatever started it, and `host_busy` is high with it.
- R7: A recall raises `xfer_clear` for CLEAR_CYC cycles, and then, with no gap, `xfer_load` for LOAD_CYC cycles. `xfer_clear` rises one cycle after the request when the host is idle.
- R8: An automatic store is triggered by a low-to-high transition of `pwr_fail`. A level that is already high during reset does not trigger one. The store begins 1+DELAY_CYC cycles after the transition.
- R9: A recall requested during a store is queued and starts two cycles after the store ends. A store requested during a recall is handled the same way. A queued line or power-fail store checks the dirty flag again when it leaves the queue, so after a recall it is dropped.
- R10: A software store or recall is not launched from idle while `host_rd` or `host_wr` is high. It starts on the cycle after both are low.
- R11: `host_busy` is high exactly while any store, clear or load phase is active.
- R12: After reset all transfer strobes, `hs_pull_en`, `host_busy` and `wr_inhibit` are low, and the dirty flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_store_req | input | 1 | One-cycle software store request |
| sw_recall_req | input | 1 | One-cycle software recall request |
| hs_line_in | input | 1 | Level of the shared active-low handshake line (asynchronous) |
| pwr_fail | input | 1 | Power-fail comparator output, high when supply is failing |
| host_rd | input | 1 | Host read strobe, high while a read is in progress |
| host_wr | input | 1 | Host write strobe, high while a write is in progress |
| hs_pull_en | output | 1 | Open-drain enable: 1 pulls the handshake line low |
| xfer_store | output | 1 | Array-to-shadow transfer strobe |
| xfer_clear | output | 1 | Recall phase one: clear the array |
| xfer_load | output | 1 | Recall phase two: load shadow into array |
| host_busy | output | 1 | Array access by the host is blocked |
| wr_inhibit | output | 1 | New host writes are refused |

## Verification
The bench builds the controller with these parameters:

| Parameter | Value |
|---|---|
| DELAY_CYC | 3 |
| STORE_CYC | 5 |
| CLEAR_CYC | 2 |
| LOAD_CYC | 3 |
| SYNC_STAGES | 2 |

With these values every transfer ends within a few cycles. That makes it possible to sweep each store source against both dirty-flag states and to compare exact start cycles and durations, computed from the parameters, for every case. The short store and recall lengths also let one run cover the queueing cases, where one transfer is requested while another is running, and the write-continuation corner around the line's falling edge.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WINDOW = 3'd1,
    ST_STORE  = 3'd2,
    ST_CLEAR  = 3'd3,
    ST_LOAD   = 3'd4
  } nvsr_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvsr_sync.sv
module nvsr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/nvsr_timer.sv
module nvsr_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/nvsr_ctrl.sv
module nvsr_ctrl
  import nvsr_pkg::*;
#(
  parameter int DELAY_CYC   = 16,
  parameter int STORE_CYC   = 64,
  parameter int CLEAR_CYC   = 8,
  parameter int LOAD_CYC    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  input  logic hs_line_in,
  input  logic pwr_fail,
  input  logic host_rd,
  input  logic host_wr,
  output logic hs_pull_en,
  output logic xfer_store,
  output logic xfer_clear,
  output logic xfer_load,
  output logic host_busy,
  output logic wr_inhibit
);

  localparam int MAX_CYC = max2(max2(DELAY_CYC, STORE_CYC), max2(CLEAR_CYC, LOAD_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] LD_DELAY = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] LD_STORE = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] LD_CLEAR = CW'(CLEAR_CYC - 1);
  localparam logic [CW-1:0] LD_LOAD  = CW'(LOAD_CYC - 1);

  nvsr_state_e   state_q, state_d;
  logic          line_q, line_prev_q, pf_prev_q;
  logic          dirty_q, wr_cont_q;
  logic          pend_sw_q, pend_hw_q, pend_rc_q;
  logic          pend_sw_d, pend_hw_d, pend_rc_d;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  // Handshake line read-back (also sees this block's own pull)
  nvsr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
    .clk (clk),
    .rst (rst),
    .d   (hs_line_in),
    .q   (line_q)
  );

  nvsr_timer #(.W(CW)) u_phase_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  logic line_low, line_fall, pf_rise, quiet, wr_acc, xfer_done;

  assign line_low  = ~line_q;
  assign line_fall = line_prev_q & ~line_q;
  assign pf_rise   = pwr_fail & ~pf_prev_q;
  assign quiet     = ~host_rd & ~host_wr;
  assign xfer_done = tmr_zero & ((state_q == ST_STORE) | (state_q == ST_LOAD));

  // Write gating: new writes refused in window or while line low; an
  // accepted write keeps going until its strobe drops.
  assign wr_inhibit = host_busy |
                      (((state_q == ST_WINDOW) | line_low) & ~wr_cont_q);
  assign wr_acc     = host_wr & ~wr_inhibit;

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    pend_sw_d = pend_sw_q | sw_store_req;
    pend_hw_d = pend_hw_q | line_fall | pf_rise;
    pend_rc_d = pend_rc_q | sw_recall_req;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_hw_d && !dirty_q) pend_hw_d = 1'b0;
        if (pend_hw_d) begin
          state_d   = ST_WINDOW;
          tmr_load  = 1'b1;
          tmr_val   = LD_DELAY;
          pend_hw_d = 1'b0;
          pend_sw_d = 1'b0;
        end else if (pend_sw_d) begin
          if (quiet) begin
            state_d   = ST_STORE;
            tmr_load  = 1'b1;
            tmr_val   = LD_STORE;
            pend_sw_d = 1'b0;
          end
        end else if (pend_rc_d && quiet) begin
          state_d   = ST_CLEAR;
          tmr_load  = 1'b1;
          tmr_val   = LD_CLEAR;
          pend_rc_d = 1'b0;
        end
      end
      ST_WINDOW: begin
        pend_sw_d = 1'b0;
        pend_hw_d = 1'b0;
        if (tmr_zero) begin
          state_d  = ST_STORE;
          tmr_load = 1'b1;
          tmr_val  = LD_STORE;
        end
      end
      ST_STORE: begin
        pend_sw_d = 1'b0;
        pend_hw_d = 1'b0;
        if (tmr_zero) state_d = ST_IDLE;
      end
      ST_CLEAR: begin
        pend_rc_d = 1'b0;
        if (tmr_zero) begin
          state_d  = ST_LOAD;
          tmr_load = 1'b1;
          tmr_val  = LD_LOAD;
        end
      end
      ST_LOAD: begin
        pend_rc_d = 1'b0;
        if (tmr_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      line_prev_q <= 1'b1;
      pf_prev_q   <= 1'b1;
      dirty_q     <= 1'b0;
      wr_cont_q   <= 1'b0;
      pend_sw_q   <= 1'b0;
      pend_hw_q   <= 1'b0;
      pend_rc_q   <= 1'b0;
      hs_pull_en  <= 1'b0;
      xfer_store  <= 1'b0;
      xfer_clear  <= 1'b0;
      xfer_load   <= 1'b0;
      host_busy   <= 1'b0;
    end else begin
      state_q     <= state_d;
      line_prev_q <= line_q;
      pf_prev_q   <= pwr_fail;
      wr_cont_q   <= wr_acc;
      pend_sw_q   <= pend_sw_d;
      pend_hw_q   <= pend_hw_d;
      pend_rc_q   <= pend_rc_d;
      if (xfer_done)   dirty_q <= 1'b0;
      else if (wr_acc) dirty_q <= 1'b1;
      hs_pull_en  <= (state_d == ST_STORE);
      xfer_store  <= (state_d == ST_STORE);
      xfer_clear  <= (state_d == ST_CLEAR);
      xfer_load   <= (state_d == ST_LOAD);
      host_busy   <= (state_d == ST_STORE) | (state_d == ST_CLEAR) |
                     (state_d == ST_LOAD);
    end
  end

  // Flag only rises after an accepted host write
  assert_dirty_from_write_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(dirty_q) |-> $past(host_wr && !wr_inhibit));

  // Any completed transfer leaves the flag clear
  assert_dirty_clear_after_xfer_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(host_busy) |-> !dirty_q);

  // A window is only opened when the flag was set
  assert_window_needs_dirty_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WINDOW && $past(state_q) == ST_IDLE) |-> $past(dirty_q));

  // Load phase follows the clear phase with no gap
  assert_load_follows_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_clear) |-> xfer_load);

  // Stores always refuse host writes
  assert_store_blocks_write_R5: assert property (@(posedge clk) disable iff (rst)
    xfer_store |-> wr_inhibit);

endmodule

// File: tb/nvsr_ctrl_test.sv
module nvsr_ctrl_test;

  localparam int D  = 3;
  localparam int S  = 5;
  localparam int C  = 2;
  localparam int L  = 3;
  localparam int SY = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_store_req = 1'b0, sw_recall_req = 1'b0;
  logic pwr_fail = 1'b0, host_rd = 1'b0, host_wr = 1'b0, ext_pull = 1'b0;
  logic hs_line;
  logic hs_pull_en, xfer_store, xfer_clear, xfer_load, host_busy, wr_inhibit;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  assign hs_line = ~(hs_pull_en | ext_pull);

  nvsr_ctrl #(.DELAY_CYC(D), .STORE_CYC(S), .CLEAR_CYC(C), .LOAD_CYC(L),
              .SYNC_STAGES(SY)) uut (
    .clk(clk), .rst(rst), .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req),
    .hs_line_in(hs_line), .pwr_fail(pwr_fail), .host_rd(host_rd), .host_wr(host_wr),
    .hs_pull_en(hs_pull_en), .xfer_store(xfer_store), .xfer_clear(xfer_clear),
    .xfer_load(xfer_load), .host_busy(host_busy), .wr_inhibit(wr_inhibit));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    settle(3);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_pulse();
    @(negedge clk); host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  // Returns negedge index of first store cycle (0 = none), its length and
  // count of store cycles where pull/busy/inhibit were not all high.
  task automatic watch_store(input int limit, output int lat, output int dur, output int bad);
    lat = 0; dur = 0; bad = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      sw_store_req = 1'b0; sw_recall_req = 1'b0;
      if (xfer_store) begin lat = i; break; end
    end
    if (lat != 0)
      while (xfer_store) begin
        dur++;
        if (!hs_pull_en || !host_busy || !wr_inhibit) bad++;
        @(negedge clk);
      end
  endtask

  task automatic clean();
    int a, b, c;
    @(negedge clk); sw_store_req = 1'b1;
    watch_store(S + 4, a, b, c);
    settle(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    int lat, dur, bad, mism, idx;
    do_reset();

    // R12: reset state
    check({hs_pull_en, xfer_store, xfer_clear, xfer_load, host_busy, wr_inhibit} == 6'b0,
          "R12", {hs_pull_en, xfer_store, xfer_clear, xfer_load, host_busy, wr_inhibit}, 0);

    // R2 / R5: clean flag, line request skipped; write while line low refused
    @(negedge clk); ext_pull = 1'b1;
    watch_store(SY + 1 + D + 6, lat, dur, bad);
    check(lat == 0, "R2", lat, 0);
    check(wr_inhibit == 1'b1, "R5", wr_inhibit, 1);
    write_pulse();
    @(negedge clk); ext_pull = 1'b0;
    settle(6);
    @(negedge clk); ext_pull = 1'b1;
    watch_store(SY + 1 + D + 6, lat, dur, bad);
    check(lat == 0, "R5 refused write left flag clear", lat, 0);
    ext_pull = 1'b0;
    settle(6);

    // Sweep: source x flag state (R2 R3 R4 R6 R8)
    for (int k = 0; k < 3; k++) begin
      for (int d = 0; d < 2; d++) begin
        int exp_lat;
        clean();
        if (d != 0) write_pulse();
        @(negedge clk);
        case (k)
          0: sw_store_req = 1'b1;
          1: ext_pull = 1'b1;
          default: pwr_fail = 1'b1;
        endcase
        watch_store(SY + 1 + D + 6, lat, dur, bad);
        exp_lat = (k == 0) ? 1 : (k == 1) ? SY + 1 + D : 1 + D;
        if (k == 0 || d != 0) begin
          check(lat == exp_lat, k == 0 ? "R3" : (k == 1 ? "R4" : "R8"), lat, exp_lat);
          check(dur == S, "R3 store length", dur, S);
          check(bad == 0, "R6", bad, 0);
        end else begin
          check(lat == 0, "R2", lat, 0);
        end
        ext_pull = 1'b0; pwr_fail = 1'b0;
        settle(6);
      end
    end

    // R1 cleared by store: repeat line request after a completed store
    write_pulse();
    @(negedge clk); ext_pull = 1'b1;
    watch_store(SY + 1 + D + 6, lat, dur, bad);
    settle(2);
    ext_pull = 1'b0; settle(6);
    @(negedge clk); ext_pull = 1'b1;
    watch_store(SY + 1 + D + 6, lat, dur, bad);
    check(lat == 0, "R1 store clears flag", lat, 0);
    ext_pull = 1'b0; settle(6);

    // R7 / R11: recall phases, then R1 recall clears the flag
    write_pulse();
    @(negedge clk); sw_recall_req = 1'b1;
    mism = 0;
    for (int i = 1; i <= C + L + 3; i++) begin
      bit ec, el;
      @(negedge clk); sw_recall_req = 1'b0;
      ec = (i >= 1) && (i <= C);
      el = (i > C) && (i <= C + L);
      if (xfer_clear != ec || xfer_load != el || xfer_store) mism++;
      if (host_busy != (ec | el)) mism++;
      if ((ec | el) && !wr_inhibit) mism++;
    end
    check(mism == 0, "R7 R11 recall phases", mism, 0);
    @(negedge clk); ext_pull = 1'b1;
    watch_store(SY + 1 + D + 6, lat, dur, bad);
    check(lat == 0, "R1 recall clears flag", lat, 0);
    ext_pull = 1'b0; settle(6);

    // R9a: recall requested during store
    @(negedge clk); sw_store_req = 1'b1;
    mism = 0;
    for (int i = 1; i <= S + C + L + 4; i++) begin
      @(negedge clk);
      if (i == 1) sw_store_req = 1'b0;
      if (i == 2) sw_recall_req = 1'b1;
      if (i == 3) sw_recall_req = 1'b0;
      if (xfer_store != (i >= 1 && i <= S)) mism++;
      if (xfer_clear != (i >= S + 2 && i <= S + 1 + C)) mism++;
      if (xfer_load != (i >= S + 2 + C && i <= S + 1 + C + L)) mism++;
    end
    check(mism == 0, "R9 recall queued behind store", mism, 0);
    settle(6);

    // R9b: store requested during recall
    @(negedge clk); sw_recall_req = 1'b1;
    mism = 0;
    for (int i = 1; i <= S + C + L + 4; i++) begin
      @(negedge clk);
      if (i == 1) begin sw_recall_req = 1'b0; sw_store_req = 1'b1; end
      if (i == 2) sw_store_req = 1'b0;
      if (xfer_clear != (i >= 1 && i <= C)) mism++;
      if (xfer_load != (i > C && i <= C + L)) mism++;
      if (xfer_store != (i >= C + L + 2 && i <= C + L + 1 + S)) mism++;
    end
    check(mism == 0, "R9 store queued behind recall", mism, 0);
    settle(6);

    // R9c: power-fail store queued behind recall re-checks the flag
    write_pulse();
    @(negedge clk); sw_recall_req = 1'b1;
    @(negedge clk); sw_recall_req = 1'b0; pwr_fail = 1'b1;
    watch_store(C + L + D + 8, lat, dur, bad);
    check(lat == 0, "R9 queued auto store dropped", lat, 0);
    pwr_fail = 1'b0; settle(4);

    // R10: software store deferred while a read runs
    @(negedge clk); host_rd = 1'b1; sw_store_req = 1'b1;
    idx = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (i == 1) sw_store_req = 1'b0;
      if (i == 4) host_rd = 1'b0;
      if (xfer_store && idx == 0) idx = i;
    end
    check(idx == 5, "R10", idx, 5);
    settle(6);

    // R4: reads during the window do not move the store
    write_pulse();
    @(negedge clk); host_rd = 1'b1; ext_pull = 1'b1;
    watch_store(SY + 1 + D + 6, lat, dur, bad);
    check(lat == SY + 1 + D, "R4 reads in window", lat, SY + 1 + D);
    host_rd = 1'b0; ext_pull = 1'b0; settle(6);

    // R5: write in progress at line fall finishes, later writes refused
    @(negedge clk); host_wr = 1'b1;
    mism = 0; idx = 0;
    for (int i = 1; i <= SY + 1 + D + S + 3; i++) begin
      @(negedge clk);
      if (i == 1) ext_pull = 1'b1;
      if (i >= 2 && i <= 4 && wr_inhibit) mism++;
      if (i == 4) host_wr = 1'b0;
      if (i == 5 && !wr_inhibit) mism++;
      if (xfer_store && idx == 0) idx = i;
    end
    check(mism == 0, "R5 write continuation", mism, 0);
    check(idx == 1 + SY + 1 + D, "R4 store after window", idx, 1 + SY + 1 + D);
    check(wr_inhibit == 1'b1, "R5 held low after store", wr_inhibit, 1);
    @(negedge clk); ext_pull = 1'b0;
    @(negedge clk);
    check(wr_inhibit == 1'b1, "R5 release stage 1", wr_inhibit, 1);
    @(negedge clk);
    check(wr_inhibit == 1'b0, "R5 release after sync", wr_inhibit, 0);
    settle(4);

    // R8: power-fail already high through reset does not trigger
    pwr_fail = 1'b1;
    do_reset();
    write_pulse();
    watch_store(D + 8, lat, dur, bad);
    check(lat == 0, "R8 level at reset", lat, 0);
    @(negedge clk); pwr_fail = 1'b0;
    @(negedge clk); pwr_fail = 1'b1;
    watch_store(D + 8, lat, dur, bad);
    check(lat == 1 + D, "R8 rise after reset", lat, 1 + D);
    pwr_fail = 1'b0; settle(4);

    finish_up();
  end

endmodule